// File: doc/BRIEF.md
# Variable-Strength ECC Way Manager

This block holds the per-way protection state for a set-associative cache that runs at reduced supply voltage. Each way has a valid flag, a strong-protection flag and a disable flag. Each set also has a small shared pool of spare parity slots. A way whose strong-protection flag is clear is read through a short single-correct decode path. A way whose flag is set is read through a long multi-bit decode path, and its extra parity sits in one of the set's pool slots. The block records which slot belongs to which way.

Requests arrive one at a time with a set, a way and a request type: read, fill, allocate a strong-protection slot, or kill (mark the way faulty). Reads to a usable way start a per-set latency engine. That engine stands in for the decoder, passes the stored word through and pulses a completion strobe after the latency the way's protection needs. A set with a read in flight refuses new requests until that read finishes. Other sets keep accepting requests. If an allocation finds the pool full, the block disables the way rather than leaving it weakly protected. Disabled ways are never filled, allocated or hit.

Top module: `vsecc_way_mgr`

## Requirements
- R1: After reset, req_ready_o is 1. rd_done_o, grant_o, ovf_o, blk_o and miss_o are 0. Every way is invalid, unprotected and enabled.
- R2: A fill (req_type_i=1) stores req_data_i and marks the way valid. A read (req_type_i=0) of a valid way whose strong flag is clear raises rd_done_o[set] for exactly one cycle, 2 cycles after the accepting edge. At that point rd_path_o[set]=0 and rd_data_o holds the filled word.
- R3: An allocate (req_type_i=2) to an enabled way without a slot grants the lowest-numbered free slot of its set. It pulses grant_o with slot_o equal to that index, and sets the way's strong flag. An allocate to a way that already holds a slot pulses grant_o with the same slot and consumes no new one.
- R4: A read of a valid way whose strong flag is set raises rd_done_o[set] 16 cycles after the accepting edge, not earlier, with rd_path_o[set]=1.
- R5: An allocate that finds all 4 slots of its set in use pulses ovf_o, gives no grant, and disables the way.
- R6: A read, fill or allocate to a disabled way pulses blk_o, causes no completion, and changes no state.
- R7: A kill (req_type_i=3) disables the way, clears its valid and strong flags, and returns its slot to the pool, where the next allocate in that set can take it.
- R8: While a read is in flight in a set, req_ready_o is 0 for requests addressed to that set and such requests take no effect. req_ready_o stays 1 for other sets.
- R9: A read of an enabled way that is not valid pulses miss_o and causes no completion.
- R10: Each set has its own slot pool. A full pool in one set does not affect grants in another.
- R11: Responses grant_o, ovf_o, blk_o, miss_o and slot_o are valid for one cycle, the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Addressed set can accept |
| req_type_i | input | 2 | 0 read, 1 fill, 2 allocate, 3 kill |
| req_set_i | input | SW | Set index |
| req_way_i | input | WW | Way index |
| req_data_i | input | DATA_W | Fill data |
| rd_done_o | output | NUM_SETS | Per-set read completion strobe |
| rd_path_o | output | NUM_SETS | Per-set decode path: 0 single-correct, 1 multi-bit |
| rd_data_o | output | NUM_SETS*DATA_W | Per-set read data, set s at bits s*DATA_W |
| grant_o | output | 1 | Slot granted |
| ovf_o | output | 1 | Pool full, way disabled |
| blk_o | output | 1 | Request hit a disabled way |
| miss_o | output | 1 | Read hit an invalid way |
| slot_o | output | PW | Granted slot index |

## Verification
The bench drives inputs on the falling edge and counts rising edges from the one that accepts the request. Status responses are sampled one falling edge after the accepting edge. Read completion is checked to be low on every falling edge before edge 2 (single-correct) or edge 16 (multi-bit), high exactly there, and low again one edge later. A held-off request is kept on the pins across a rising edge, and its absence of effect is shown through the responses and a later slot grant.

// File: rtl/vsecc_pkg.sv
package vsecc_pkg;
  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_FILL  = 2'd1,
    REQ_ALLOC = 2'd2,
    REQ_KILL  = 2'd3
  } req_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vsecc_slot_pick.sv
module vsecc_slot_pick #(
  parameter int NUM_SLOTS = 4,
  localparam int PW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] used_i,
  output logic                 found_o,
  output logic [PW-1:0]        idx_o
);
  // lowest free index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!used_i[i]) begin
        found_o = 1'b1;
        idx_o   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/vsecc_rd_engine.sv
module vsecc_rd_engine #(
  parameter int DATA_W   = 32,
  parameter int BASE_LAT = 1,
  parameter int SEC_LAT  = 1,
  parameter int MEC_LAT  = 15,
  localparam int SEC_TOT = BASE_LAT + SEC_LAT,
  localparam int MEC_TOT = BASE_LAT + MEC_LAT,
  localparam int CW      = (vsecc_pkg::max_i(SEC_TOT, MEC_TOT) > 2) ?
                           $clog2(vsecc_pkg::max_i(SEC_TOT, MEC_TOT)) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ext_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              path_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CW-1:0]     cnt_q;
  logic              busy_q, done_q, path_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      path_q <= 1'b0;
      data_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      path_q <= ext_i;
      data_q <= data_i;
      cnt_q  <= ext_i ? CW'(MEC_TOT - 1) : CW'(SEC_TOT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign path_o = path_q;
  assign data_o = data_q;

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/vsecc_way_mgr.sv
module vsecc_way_mgr
  import vsecc_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int NUM_WAYS  = 16,
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter int BASE_LAT  = 1,
  parameter int SEC_LAT   = 1,
  parameter int MEC_LAT   = 15,
  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WW = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int PW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [1:0]                 req_type_i,
  input  logic [SW-1:0]              req_set_i,
  input  logic [WW-1:0]              req_way_i,
  input  logic [DATA_W-1:0]          req_data_i,
  output logic [NUM_SETS-1:0]        rd_done_o,
  output logic [NUM_SETS-1:0]        rd_path_o,
  output logic [NUM_SETS*DATA_W-1:0] rd_data_o,
  output logic                       grant_o,
  output logic                       ovf_o,
  output logic                       blk_o,
  output logic                       miss_o,
  output logic [PW-1:0]              slot_o
);
  logic [NUM_WAYS-1:0]  vld_q [NUM_SETS];
  logic [NUM_WAYS-1:0]  ext_q [NUM_SETS];
  logic [NUM_WAYS-1:0]  dis_q [NUM_SETS];
  logic [PW-1:0]        ptr_q [NUM_SETS][NUM_WAYS];
  logic [NUM_SLOTS-1:0] used_q[NUM_SETS];
  logic [DATA_W-1:0]    mem_q [NUM_SETS][NUM_WAYS];

  logic [NUM_SETS-1:0]  busy, start;
  req_e                 rt;
  logic                 acc, w_vld, w_ext, w_dis;
  logic [PW-1:0]        w_ptr, pick_idx;
  logic                 pick_found;
  logic [NUM_SLOTS-1:0] sel_used;
  logic [DATA_W-1:0]    sel_data;

  assign rt          = req_e'(req_type_i);
  assign req_ready_o = !busy[req_set_i];
  assign acc         = req_valid_i && req_ready_o;
  assign w_vld       = vld_q[req_set_i][req_way_i];
  assign w_ext       = ext_q[req_set_i][req_way_i];
  assign w_dis       = dis_q[req_set_i][req_way_i];
  assign w_ptr       = ptr_q[req_set_i][req_way_i];
  assign sel_used    = used_q[req_set_i];
  assign sel_data    = mem_q[req_set_i][req_way_i];

  vsecc_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) i_pick (
    .used_i (sel_used),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_eng
    assign start[g] = acc && (rt == REQ_READ) && (req_set_i == SW'(g)) && w_vld && !w_dis;
    vsecc_rd_engine #(
      .DATA_W(DATA_W), .BASE_LAT(BASE_LAT), .SEC_LAT(SEC_LAT), .MEC_LAT(MEC_LAT)
    ) i_eng (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start[g]),
      .ext_i  (w_ext),
      .data_i (sel_data),
      .busy_o (busy[g]),
      .done_o (rd_done_o[g]),
      .path_o (rd_path_o[g]),
      .data_o (rd_data_o[g*DATA_W +: DATA_W])
    );
  end

  // data array carries no reset; valid flag guards every read
  always_ff @(posedge clk_i) begin
    if (acc && rt == REQ_FILL && !w_dis) mem_q[req_set_i][req_way_i] <= req_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        vld_q[s]  <= '0;
        ext_q[s]  <= '0;
        dis_q[s]  <= '0;
        used_q[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) ptr_q[s][w] <= '0;
      end
      grant_o <= 1'b0;
      ovf_o   <= 1'b0;
      blk_o   <= 1'b0;
      miss_o  <= 1'b0;
      slot_o  <= '0;
    end else begin
      grant_o <= 1'b0;
      ovf_o   <= 1'b0;
      blk_o   <= 1'b0;
      miss_o  <= 1'b0;
      if (acc) begin
        unique case (rt)
          REQ_READ: begin
            if (w_dis)       blk_o  <= 1'b1;
            else if (!w_vld) miss_o <= 1'b1;
          end
          REQ_FILL: begin
            if (w_dis) blk_o <= 1'b1;
            else       vld_q[req_set_i][req_way_i] <= 1'b1;
          end
          REQ_ALLOC: begin
            if (w_dis) begin
              blk_o <= 1'b1;
            end else if (w_ext) begin
              grant_o <= 1'b1;
              slot_o  <= w_ptr;
            end else if (pick_found) begin
              grant_o <= 1'b1;
              slot_o  <= pick_idx;
              ext_q[req_set_i][req_way_i] <= 1'b1;
              ptr_q[req_set_i][req_way_i] <= pick_idx;
              used_q[req_set_i][pick_idx] <= 1'b1;
            end else begin
              // no parity slot left: retire the way
              ovf_o <= 1'b1;
              dis_q[req_set_i][req_way_i] <= 1'b1;
              vld_q[req_set_i][req_way_i] <= 1'b0;
            end
          end
          REQ_KILL: begin
            dis_q[req_set_i][req_way_i] <= 1'b1;
            vld_q[req_set_i][req_way_i] <= 1'b0;
            ext_q[req_set_i][req_way_i] <= 1'b0;
            if (w_ext) used_q[req_set_i][w_ptr] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_hold_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> !(grant_o || ovf_o || blk_o || miss_o));
  assert_pick_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_found |-> !sel_used[pick_idx]);
  assert_pick_found_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&sel_used) |-> pick_found);
  assert_ovf_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (&used_q[$past(req_set_i)]));
  assert_resp_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, ovf_o, blk_o, miss_o}));
  assert_grant_owned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> used_q[$past(req_set_i)][slot_o]);
endmodule

// File: tb/test_vsecc_way_mgr.sv
module test_vsecc_way_mgr;
  localparam int NS = 4, NW = 16, NSL = 4, DW = 32;
  localparam int SEC_L = 2, MEC_L = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_type = '0;
  logic [1:0]    req_set = '0;
  logic [3:0]    req_way = '0;
  logic [DW-1:0] req_data = '0;
  logic [NS-1:0] rd_done, rd_path;
  logic [NS*DW-1:0] rd_data;
  logic          grant, ovf, blk, miss;
  logic [1:0]    slot;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vsecc_way_mgr #(.NUM_SETS(NS), .NUM_WAYS(NW), .NUM_SLOTS(NSL), .DATA_W(DW)) i_vsecc_way_mgr (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_type_i(req_type), .req_set_i(req_set), .req_way_i(req_way), .req_data_i(req_data),
    .rd_done_o(rd_done), .rd_path_o(rd_path), .rd_data_o(rd_data),
    .grant_o(grant), .ovf_o(ovf), .blk_o(blk), .miss_o(miss), .slot_o(slot)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // drive on falling edge, return one falling edge after the accepting edge
  task automatic issue(input logic [1:0] t, input int s, input int w, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_set = 2'(s); req_way = 4'(w); req_data = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic resp(input string tag, input bit g, input bit o, input bit b, input bit m);
    chk({tag, " grant"}, grant, g);
    chk({tag, " ovf"}, ovf, o);
    chk({tag, " blk"}, blk, b);
    chk({tag, " miss"}, miss, m);
  endtask

  task automatic read_lat(input string tag, input int s, input int w, input int lat,
                          input bit path, input logic [DW-1:0] d);
    int early = 0;
    issue(2'd0, s, w, '0);
    resp({tag, " rsp"}, 0, 0, 0, 0);
    for (int k = 1; k <= lat; k++) begin
      if (k == 1) chk({tag, " busy ready"}, req_ready, 0);
      @(posedge clk); @(negedge clk);
      if (k < lat && rd_done[s]) early++;
    end
    chk({tag, " early done"}, early, 0);
    chk({tag, " done"}, rd_done[s], 1);
    chk({tag, " path"}, rd_path[s], path);
    chk({tag, " data"}, rd_data[s*DW +: DW], d);
    @(posedge clk); @(negedge clk);
    chk({tag, " done pulse"}, rd_done[s], 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", rd_done, 0);
    resp("R1", 0, 0, 0, 0);
    issue(2'd0, 0, 0, '0);
    resp("R9 miss s0w0", 0, 0, 0, 1);
    @(posedge clk); @(negedge clk);
    chk("R9 no done", rd_done, 0);
    chk("R11 miss pulse", miss, 0);
  endtask

  task automatic t_sec();
    issue(2'd1, 0, 3, 32'hA5A5_0003);
    resp("R2 fill s0w3", 0, 0, 0, 0);
    read_lat("R2 s0w3", 0, 3, SEC_L, 0, 32'hA5A5_0003);
    issue(2'd1, 1, 15, 32'h1234_5678);
    read_lat("R2 s1w15", 1, 15, SEC_L, 0, 32'h1234_5678);
  endtask

  task automatic t_alloc();
    issue(2'd2, 0, 3, '0);
    resp("R3 alloc s0w3", 1, 0, 0, 0);
    chk("R3 slot0", slot, 0);
    issue(2'd2, 0, 3, '0);
    resp("R3 realloc", 1, 0, 0, 0);
    chk("R3 same slot", slot, 0);
    issue(2'd2, 0, 5, '0);
    chk("R3 next slot", slot, 1);
    read_lat("R4 s0w3", 0, 3, MEC_L, 1, 32'hA5A5_0003);
  endtask

  task automatic t_ovf();
    issue(2'd2, 0, 6, '0);
    chk("R3 slot2", slot, 2);
    issue(2'd2, 0, 7, '0);
    chk("R3 slot3", slot, 3);
    issue(2'd2, 0, 8, '0);
    resp("R5 full", 0, 1, 0, 0);
    issue(2'd0, 0, 8, '0);
    resp("R6 read dis", 0, 0, 1, 0);
    @(posedge clk); @(negedge clk);
    chk("R6 no done", rd_done[0], 0);
    issue(2'd1, 0, 8, 32'hDEAD_BEEF);
    resp("R6 fill dis", 0, 0, 1, 0);
    issue(2'd2, 0, 8, '0);
    resp("R6 alloc dis", 0, 0, 1, 0);
    issue(2'd2, 2, 0, '0);
    resp("R10 other set", 1, 0, 0, 0);
    chk("R10 slot", slot, 0);
  endtask

  task automatic t_kill();
    issue(2'd3, 0, 5, '0);
    resp("R7 kill", 0, 0, 0, 0);
    issue(2'd2, 0, 9, '0);
    resp("R7 reuse", 1, 0, 0, 0);
    chk("R7 freed slot", slot, 1);
    issue(2'd0, 0, 5, '0);
    resp("R7 killed read", 0, 0, 1, 0);
  endtask

  task automatic t_busy();
    int k = 0;
    issue(2'd1, 1, 2, 32'h0BAD_F00D);
    issue(2'd2, 1, 2, '0);
    chk("R8 prep slot", slot, 0);
    issue(2'd0, 1, 2, '0);
    req_valid = 1'b1; req_type = 2'd2; req_set = 2'd1; req_way = 4'd4;
    #0.5;
    chk("R8 ready low", req_ready, 0);
    @(posedge clk); @(negedge clk);
    k = 1;
    resp("R8 held", 0, 0, 0, 0);
    req_set = 2'd0;
    #0.5;
    chk("R8 other set ready", req_ready, 1);
    req_valid = 1'b0;
    while (!rd_done[1] && k < 40) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
    chk("R8 done at 16", k, MEC_L);
    chk("R8 data", rd_data[DW +: DW], 32'h0BAD_F00D);
    issue(2'd2, 1, 4, '0);
    resp("R8 after", 1, 0, 0, 0);
    chk("R8 held not taken", slot, 1);
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_sec();
    t_alloc();
    t_ovf();
    t_kill();
    t_busy();
    repeat (2) @(posedge clk);
    report();
  end
endmodule